// File: doc/BRIEF.md
# Serial Set-Bit Counter with Ready/Valid Channels

This block reports how many bits are set in a data word. A word is taken in over a ready/valid input channel, and the number of ones leaves over a ready/valid output channel. Inside, a three-state controller drives a small datapath that holds a shift register and an accumulator. Once a word is accepted, the datapath moves it right by one place per cycle and adds the bit that falls out to the accumulator. It stops as soon as the shift register holds no set bits.

Because the datapath stops when no set bits remain, a word whose high-order bits are clear finishes in fewer cycles. The result stays on the output channel until a consumer accepts it. Only after that is a new word accepted. The word width is a parameter, and the count width follows from it. Reset is synchronous and active high.

Top module: `bitcnt_engine`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_valid` are low. In the cycle after `rst` falls, `in_ready` is high and `out_valid` is low.
- R2: A word is taken only at a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle that follows that edge.
- R3: Once `out_valid` rises, it stays high, and `out_count` stays unchanged, until an edge where `out_ready` is high.
- R4: `out_count`, read while `out_valid` is high, equals the number of 1 bits in the accepted word. It never exceeds W.
- R5: Let b be one plus the index of the highest set bit of the accepted word, or 0 for an all-zero word. Then `out_valid` becomes high exactly b+1 clock edges after the accepting edge.
- R6: While a word is being counted or its result is waiting, `in_ready` is low. Any `in_valid`/`in_word` activity in that time leaves the pending result unchanged.
- R7: After an edge where `out_valid` and `out_ready` are both high, `out_valid` is low and `in_ready` is high.
- R8: The accumulator starts from zero for every accepted word. A result never includes bits of an earlier word, including a word whose count was cut short by reset.
- R9: `in_ready` and `out_valid` are never high in the same cycle.
- R10: While counting, each edge raises the accumulator by exactly the bit shifted out of the low end of the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | W | Word whose set bits are counted |
| in_valid | input | 1 | Producer offers `in_word` |
| in_ready | output | 1 | Block can accept a word (idle) |
| out_count | output | $clog2(W+1) | Number of set bits in the accepted word |
| out_valid | output | 1 | `out_count` holds a finished result |
| out_ready | input | 1 | Consumer takes the result |

## Verification
On every cycle, the assertions check the following:
- the two channels exclude each other;
- `in_ready` falls after an accepted word;
- a waiting result holds steady under backpressure;
- `in_ready` returns after the result is read;
- the accumulator grows by exactly the shifted-out bit and never passes W.

Other behaviour only the bench scenarios can show. This covers that the final count matches the word's weight and that latency follows the highest set bit. It also covers that input offered while busy is ignored and that a reset in mid-count leaves nothing behind for the next word.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } ctrl_st_e;

  // Controller transition: take = input transfer, empty = datapath has no
  // set bits left, give = output transfer.
  function automatic ctrl_st_e ctrl_next(ctrl_st_e s, logic take, logic empty,
                                         logic give);
    ctrl_st_e n;
    n = s;
    case (s)
      ST_IDLE:  if (take)  n = ST_COUNT;
      ST_COUNT: if (empty) n = ST_DONE;
      ST_DONE:  if (give)  n = ST_IDLE;
      default:  n = ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bitcnt_ctrl.sv
module bitcnt_ctrl
  import bitcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic dp_empty,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);

  ctrl_st_e st_q;
  logic     take;
  logic     give;

  assign in_ready  = (st_q == ST_IDLE) && !rst;
  assign out_valid = (st_q == ST_DONE) && !rst;
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;
  assign load      = take;
  assign step      = (st_q == ST_COUNT) && !dp_empty;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= ctrl_next(st_q, take, dp_empty, give);
  end

  // R9
  excl_chan_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ready, out_valid}));

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/bitcnt_datapath.sv
module bitcnt_datapath #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  word,
  output logic          empty,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] MAX_CNT = CW'(W);

  logic [W-1:0]  shf_q;
  logic [CW-1:0] acc_q;

  function automatic logic [CW-1:0] acc_bit(logic [CW-1:0] c, logic b);
    return c + CW'(b);
  endfunction

  assign empty = (shf_q == '0);
  assign count = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shf_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      shf_q <= word;
      acc_q <= '0;
    end else if (step) begin
      shf_q <= shf_q >> 1;
      acc_q <= acc_bit(acc_q, shf_q[0]);
    end
  end

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> ((acc_q - $past(acc_q)) == CW'($past(shf_q[0]))));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q <= MAX_CNT);

endmodule

// File: rtl/bitcnt_engine.sv
module bitcnt_engine #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  in_word,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [CW-1:0] out_count,
  output logic          out_valid,
  input  logic          out_ready
);

  logic dp_load;
  logic dp_step;
  logic dp_empty;

  bitcnt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .dp_empty  (dp_empty),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (dp_load),
    .step      (dp_step)
  );

  bitcnt_datapath #(.W(W), .CW(CW)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .load  (dp_load),
    .step  (dp_step),
    .word  (in_word),
    .empty (dp_empty),
    .count (out_count)
  );

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count)));

endmodule

// File: tb/bitcnt_engine_tb.sv
module bitcnt_engine_tb;

  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);
  localparam int NV = 8;
  localparam logic [W-1:0] VEC_W [NV] =
    '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C, 8'h10, 8'h7F};
  localparam int VEC_C [NV] = '{0, 1, 1, 8, 4, 4, 1, 7};

  logic          clk = 0;
  logic          rst = 1;
  logic [W-1:0]  in_word = '0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [CW-1:0] out_count;
  logic          out_valid;
  logic          out_ready = 0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bitcnt_engine #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .out_count(out_count), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bitlen(logic [W-1:0] w);
    int b = 0;
    for (int i = 0; i < W; i++) if (w[i]) b = i + 1;
    return b;
  endfunction

  // Offer a word, wait for it to be taken, then return latency in edges.
  task automatic offer(logic [W-1:0] w, output int lat);
    @(negedge clk);
    in_word  = w;
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R2 ready low after accept", in_ready, 0);
    lat = 0;
    forever begin
      if (out_valid) break;
      if (lat > W + 5) break;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk("R7 valid low after read", out_valid, 0);
    chk("R7 ready high after read", in_ready, 1);
  endtask

  initial begin
    int lat;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", in_ready, 0);
    chk("R1 valid low in reset", out_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 ready high after reset", in_ready, 1);
    chk("R1 valid low after reset", out_valid, 0);

    // Table: R4 count, R5 latency, R8 fresh count per word
    for (int k = 0; k < NV; k++) begin
      offer(VEC_W[k], lat);
      chk("R4 count", int'(out_count), VEC_C[k]);
      chk("R5 latency", lat, bitlen(VEC_W[k]) + 1);
      chk("R9 ready low while valid", in_ready, 0);
      drain();
    end

    // R6 and R3: offer another word while busy, then backpressure
    @(negedge clk);
    in_word  = 8'hF0;
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_word = 8'hFF;
    for (int c = 0; c < 12 && !out_valid; c++) begin
      chk("R6 ready low while busy", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0;
    chk("R6 result after busy input", int'(out_count), 4);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R3 valid held", out_valid, 1);
      chk("R3 count held", int'(out_count), 4);
    end
    drain();

    // R1/R8: reset mid-count, next word counts from zero
    @(negedge clk);
    in_word  = 8'hFE;
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R1 ready low in mid reset", in_ready, 0);
    chk("R1 valid low in mid reset", out_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 ready high after mid reset", in_ready, 1);
    chk("R1 valid low after mid reset", out_valid, 0);
    offer(8'h03, lat);
    chk("R8 count after reset", int'(out_count), 2);
    chk("R5 latency after reset", lat, 3);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule